// File: doc/BRIEF.md
# Four-Channel Double-Buffered DAC Serial Loader

This block is the digital front end of a four-channel digital-to-analog converter. A host shifts a word in serially on `sdi`, one bit per rising edge of `clk`, while `cs_n` is held low. When `cs_n` returns high, the most recent eighteen bits are split into a two-bit channel address and a sixteen-bit code. The code goes into that channel's input register. A separate active-low load level, `load_n`, copies all four input registers into the four output (DAC) registers on the same edge. With `load_n` held low the second stage simply follows the first, so writes reach the outputs without staging.

The serial register also drives `sdo`, delayed so that devices can be chained: the `sdo` of one device feeds the `sdi` of the next, and all of them share `cs_n` and `clk`. A preset input forces every register to zero code or to half-scale, depending on `preset_mid`. A reset input clears everything to zero and stands in for power-on clearing. The analog conversion lies outside this block. Its outputs are the four DAC register words, packed into `dac_word`.

Top module: `dacload_ctrl`

## Requirements
- R1: The used frame is the final 18 bits shifted in, most significant first. Its upper two bits are the address and its lower sixteen bits are the code. Address 0, 1, 2 and 3 selects channel A, B, C and D, which appear at `dac_word` bits [15:0], [31:16], [47:32] and [63:48].
- R2: A write happens only on the first rising `clk` edge at which `cs_n` is high after it was low at the previous edge. It changes only the addressed channel's input register. No input register changes at an edge where `cs_n` is low.
- R3: When more than 18 bits are shifted in before `cs_n` rises, the earlier extra bits have no effect on which channel is written or on the value written.
- R4: While `load_n` is high, the DAC registers hold their value, even across input-register writes.
- R5: At every rising edge with `load_n` low, all four DAC registers take the value their input registers hold after that edge. This includes a write made at the same edge, so holding `load_n` low makes the outputs follow writes directly.
- R6: While `rst_n` is low at a rising edge, every input and DAC register clears to zero and `sdo` clears to 0. This takes priority over the preset, writes and loads.
- R7: While `preset_n` is low at a rising edge, every input and DAC register is set to 16'h0000 if `preset_mid` is 0, or to 16'h8000 if it is 1. This overrides a write or a load at the same edge.
- R8: A bit sampled from `sdi` at rising edge k, with `cs_n` low, is the value of `sdo` at rising edge k+19, counting only edges with `cs_n` low. `sdo` changes only on falling edges of `clk`.
- R9: While `cs_n` stays high, `sdi` is ignored and `sdo` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and register clock; `sdi` is sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low clear to zero (power-on clearing) |
| cs_n | input | 1 | Active-low select; low shifts, the rise writes |
| sdi | input | 1 | Serial data in, address and code MSB first |
| sdo | output | 1 | Delayed serial data out for chaining, updated on falling edges |
| load_n | input | 1 | Active-low level that copies input registers to DAC registers |
| preset_n | input | 1 | Synchronous active-low preset of all registers |
| preset_mid | input | 1 | Preset value select: 0 gives zero code, 1 gives half-scale |
| dac_word | output | 64 | Four 16-bit DAC register words, channel A in the low bits |

## Verification
The write path is driven with one exact 18-bit frame per channel in a scrambled channel order, with `load_n` high throughout. This tells the address decoding apart from the staging of the outputs. Frames of 22 and 40 bits show that only the final 18 bits count, and the 40-bit stream also checks the `sdo` delay bit by bit. Further runs cover a write with `load_n` held low, a preset that coincides with a `cs_n` rise, and a reset that coincides with a preset. Together these separate the transparent mode and both priority orders from the normal two-stage path.

// File: rtl/dacload_pkg.sv
`timescale 1ns/1ps
// Package: default geometry shared by the serial loader and its checker.
// Assumes the channel count is a power of two so the address fills its field.
package dacload_pkg;
    localparam int unsigned DEF_NCH    = 4;
    localparam int unsigned DEF_DATA_W = 16;
endpackage

// File: rtl/dacload_shifter.sv
`timescale 1ns/1ps
// Serial shift register with delayed daisy-chain output.
// Shifts sdi in on rising clk while cs_n is low. Exposes the latest FRAME_W
// bits as the frame. Drives sdo from the oldest stage on falling clk edges.
// Assumes rst_n is stable around both clock edges.
module dacload_shifter #(
    parameter int unsigned FRAME_W = 18,
    parameter int unsigned SHIFT_W = FRAME_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sdi,
    output logic [FRAME_W-1:0] frame,
    output logic               sdo
);
    logic [SHIFT_W-1:0] sr_q;
    logic               sdo_q;

    // Shift one bit per rising edge while the device is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= '0;
        else if (!cs_n) sr_q <= {sr_q[SHIFT_W-2:0], sdi};
    end

    // Re-time the oldest stage to the falling edge for the next device.
    always_ff @(negedge clk) begin
        if (!rst_n) sdo_q <= 1'b0;
        else        sdo_q <= sr_q[SHIFT_W-1];
    end

    assign frame = sr_q[FRAME_W-1:0];
    assign sdo   = sdo_q;
endmodule

// File: rtl/dacload_strobe.sv
`timescale 1ns/1ps
// Write strobe generator: one-cycle pulse at the first rising edge that
// sees cs_n high after an edge that saw it low. Assumes clk keeps running
// for at least one edge after cs_n rises.
module dacload_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic wr_pulse
);
    logic cs_q;

    // Remember the select level seen at the previous rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    assign wr_pulse = cs_n & ~cs_q;
endmodule

// File: rtl/dacload_bank.sv
`timescale 1ns/1ps
// Two-stage register bank: NCH input registers written one at a time by
// address, and NCH DAC registers copied all at once while load_n is low.
// Priority: rst_n, then preset_n, then write or load.
module dacload_bank #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  preset_n,
    input  logic                  preset_mid,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  load_n,
    output logic [NCH*DATA_W-1:0] in_word,
    output logic [NCH*DATA_W-1:0] dac_word
);
    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] preset_val;

    // Pick the preset code from the level pin.
    always_comb preset_val = preset_mid ? MID_CODE : '0;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [DATA_W-1:0] in_q, in_nxt, dac_q;

        // Next input-register value: preset, addressed write, or hold.
        always_comb begin
            if (!preset_n)                          in_nxt = preset_val;
            else if (wr && wr_addr == ADDR_W'(ch))  in_nxt = wr_data;
            else                                    in_nxt = in_q;
        end

        // First stage storage.
        always_ff @(posedge clk) begin
            if (!rst_n) in_q <= '0;
            else        in_q <= in_nxt;
        end

        // Second stage: preset, or follow the first stage while load is low.
        always_ff @(posedge clk) begin
            if (!rst_n)         dac_q <= '0;
            else if (!preset_n) dac_q <= preset_val;
            else if (!load_n)   dac_q <= in_nxt;
        end

        assign in_word[ch*DATA_W +: DATA_W]  = in_q;
        assign dac_word[ch*DATA_W +: DATA_W] = dac_q;
    end
endmodule

// File: rtl/dacload_ctrl.sv
`timescale 1ns/1ps
// Top of the four-channel DAC serial loader. Joins the shifter, the write
// strobe and the register bank. The frame is address bits above data bits,
// sent MSB first. sdo lags sdi by SDO_DELAY selected clock edges.
module dacload_ctrl #(
    parameter int unsigned NCH    = dacload_pkg::DEF_NCH,
    parameter int unsigned DATA_W = dacload_pkg::DEF_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sdi,
    output logic                  sdo,
    input  logic                  load_n,
    input  logic                  preset_n,
    input  logic                  preset_mid,
    output logic [NCH*DATA_W-1:0] dac_word
);
    localparam int unsigned ADDR_W    = $clog2(NCH);
    localparam int unsigned FRAME_W   = ADDR_W + DATA_W;
    localparam int unsigned SDO_DELAY = FRAME_W + 1;

    logic [FRAME_W-1:0]    frame;
    logic                  wr_pulse;
    logic [NCH*DATA_W-1:0] in_word;

    dacload_shifter #(.FRAME_W(FRAME_W), .SHIFT_W(SDO_DELAY)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
        .frame(frame), .sdo(sdo)
    );

    dacload_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_pulse(wr_pulse)
    );

    dacload_bank #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .preset_mid(preset_mid),
        .wr(wr_pulse), .wr_addr(frame[FRAME_W-1 -: ADDR_W]),
        .wr_data(frame[DATA_W-1:0]), .load_n(load_n),
        .in_word(in_word), .dac_word(dac_word)
    );
endmodule

// File: rtl/dacload_ctrl_chk.sv
`timescale 1ns/1ps
// Checker for dacload_ctrl. It watches ports and the first-stage bank
// output, and is bound into every instance of the top.
module dacload_ctrl_chk #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned DATA_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n,
    input logic                  load_n,
    input logic                  preset_n,
    input logic                  preset_mid,
    input logic                  sdo,
    input logic [NCH*DATA_W-1:0] in_word,
    input logic [NCH*DATA_W-1:0] dac_word
);
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_word == '0 && in_word == '0 && sdo == 1'b0));

    a_r7_preset_value: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_n |=> dac_word == ($past(preset_mid) ? {NCH{MID}} : '0));

    a_r4_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && load_n) |=> $stable(dac_word));

    a_r5_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && !load_n) |=> dac_word == in_word);

    a_r2_no_write_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && !cs_n) |=> $stable(in_word));

    a_r9_sdo_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(sdo));
endmodule

bind dacload_ctrl dacload_ctrl_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .load_n(load_n),
    .preset_n(preset_n), .preset_mid(preset_mid), .sdo(sdo),
    .in_word(in_word), .dac_word(dac_word)
);

// File: tb/tb_dacload_ctrl.sv
`timescale 1ns/1ps
// Directed bench for dacload_ctrl: one task per scenario, each checking itself.
module tb_dacload_ctrl;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int FW  = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0, cs_n = 1'b1, sdi = 1'b0, load_n = 1'b1;
    logic preset_n = 1'b1, preset_mid = 1'b0;
    logic sdo;
    logic [NCH*DW-1:0] dac_word;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] exp_in [NCH];
    logic [DW-1:0] exp_dac [NCH];

    always #10 clk = ~clk;

    dacload_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
        .load_n(load_n), .preset_n(preset_n), .preset_mid(preset_mid),
        .dac_word(dac_word)
    );

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH*DW-1:0] pack_dac();
        logic [NCH*DW-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*DW +: DW] = exp_dac[c];
        return v;
    endfunction

    task automatic set_all(input logic [DW-1:0] v);
        for (int c = 0; c < NCH; c++) begin exp_in[c] = v; exp_dac[c] = v; end
    endtask

    // Shift n bits of v MSB first, then raise cs_n; optionally check sdo lag.
    task automatic send(input logic [63:0] v, input int n, input bit chk_sdo);
        for (int j = 0; j < n; j++) begin
            cs_n = 1'b0; sdi = v[n-1-j];
            step();
            if (chk_sdo && j >= FW) chk("R8 sdo delay", 64'(sdo), 64'(v[n-1-(j-FW)]));
        end
        cs_n = 1'b1;
        step();
        exp_in[v[FW-1:DW]] = v[DW-1:0];
        if (!load_n) for (int c = 0; c < NCH; c++) exp_dac[c] = exp_in[c];
    endtask

    task automatic pulse_load();
        load_n = 1'b0; step(); load_n = 1'b1;
        for (int c = 0; c < NCH; c++) exp_dac[c] = exp_in[c];
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step(); step();
        rst_n = 1'b1; set_all('0);
        chk("R6 reset dac", dac_word, pack_dac());
        chk("R6 reset sdo", 64'(sdo), 64'd0);
    endtask

    task automatic t_address_map();
        send({46'd0, 2'd3, 16'hD00D}, FW, 1'b0);
        send({46'd0, 2'd1, 16'hB0B1}, FW, 1'b0);
        chk("R4 no load hold", dac_word, 64'd0);
        send({46'd0, 2'd0, 16'hA11A}, FW, 1'b0);
        send({46'd0, 2'd2, 16'hC22C}, FW, 1'b0);
        chk("R4 no load hold after 4 writes", dac_word, 64'd0);
        pulse_load();
        chk("R1 R2 R5 address map after load", dac_word, pack_dac());
        chk("R1 channel C field", 64'(dac_word[47:32]), 64'h0000_C22C);
    endtask

    task automatic t_long_frame();
        send({42'd0, 4'b1101, 2'd2, 16'h1234}, 22, 1'b0);
        pulse_load();
        chk("R3 22-bit frame", dac_word, pack_dac());
    endtask

    task automatic t_sdo_chain();
        send(64'h0000_00C3_5A96_7E21, 40, 1'b1);
        pulse_load();
        chk("R3 R8 40-bit frame final bits", dac_word, pack_dac());
    endtask

    task automatic t_hold_deselected();
        logic s0;
        s0 = sdo;
        for (int j = 0; j < 25; j++) begin
            sdi = ~sdi; step();
        end
        chk("R9 sdo held while deselected", 64'(sdo), 64'(s0));
        pulse_load();
        chk("R9 R2 no write while deselected", dac_word, pack_dac());
    endtask

    task automatic t_transparent();
        load_n = 1'b0;
        send({46'd0, 2'd1, 16'hBEEF}, FW, 1'b0);
        chk("R5 transparent write", dac_word, pack_dac());
        send({46'd0, 2'd3, 16'h0F0F}, FW, 1'b0);
        chk("R5 transparent channel D", 64'(dac_word[63:48]), 64'h0F0F);
        load_n = 1'b1;
    endtask

    task automatic t_preset_override();
        for (int j = FW-1; j >= 0; j--) begin
            cs_n = 1'b0; sdi = (j >= DW) ? 1'b0 : (j % 2 == 0); step();
        end
        cs_n = 1'b1; preset_n = 1'b0; preset_mid = 1'b1; step();
        preset_n = 1'b1; set_all(16'h8000);
        chk("R7 half-scale preset beats write", dac_word, pack_dac());
        pulse_load();
        chk("R7 input regs hold half-scale", dac_word, pack_dac());
        preset_n = 1'b0; preset_mid = 1'b0; load_n = 1'b0; step();
        preset_n = 1'b1; load_n = 1'b1; set_all('0);
        chk("R7 zero preset", dac_word, pack_dac());
    endtask

    task automatic t_reset_priority();
        send({46'd0, 2'd0, 16'h7777}, FW, 1'b0);
        pulse_load();
        rst_n = 1'b0; preset_n = 1'b0; preset_mid = 1'b1; step(); step();
        rst_n = 1'b1; preset_n = 1'b1; set_all('0);
        chk("R6 reset beats preset", dac_word, pack_dac());
        chk("R6 sdo cleared", 64'(sdo), 64'd0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_address_map();
        t_long_frame();
        t_sdo_chain();
        t_hold_deselected();
        t_transparent();
        t_preset_override();
        t_reset_priority();
        finish_run();
    end
endmodule